// File: doc/BRIEF.md
# Integer Execute Unit with Compare Flags and Branch Resolution

This block is the execute stage for a 32-bit register machine. It takes one decoded instruction per beat: a 6-bit operation code, two register operands, a 16-bit immediate, a shift count and the program counter of the instruction. From these it produces a result word with a write strobe for the destination register, or a branch decision with its target address. A compare operation does not write a register. It updates three persistent status flags (equal, greater, less). Conditional jumps later read those flags, so a jump does not compare registers itself.

Instructions enter through a valid/ready input channel. Results leave through a valid/ready output channel that holds one registered beat. An input is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high when the output stage is empty, or when its beat is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds and no new instruction is taken. Each accepted instruction yields exactly one output beat, in order, one cycle after acceptance. Operand `in_a` carries the first source register. For the upper-immediate load it carries the current value of the destination register.

Top module: `exec_unit`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and all three flags (`flag_eq`, `flag_gt`, `flag_lt`) are 0.
- R2: Arithmetic wraps modulo 2^32: ADD 0x19 gives a+b, SUB 0x1A gives a-b, INC 0x15 gives a+1, DEC 0x16 gives a-1, IADD 0x25 gives a+sext(imm), ISUB 0x26 gives a-sext(imm). Each sets `out_wen`=1.
- R3: Logic operations write a bitwise result with `out_wen`=1: AND 0x1B, OR 0x1C, NOT 0x1D (~a), XOR 0x1E, NAND 0x1F, NOR 0x20, XNOR 0x21.
- R4: SHL 0x17 gives a shifted left by `in_shamt`. SHR 0x18 gives a shifted right by `in_shamt` with zero fill. Both set `out_wen`=1.
- R5: LLI 0x0B writes {16'h0000, imm}. LUI 0x0C writes {imm, a[15:0]}.
- R6: CMP 0x14 compares a with b as signed numbers. Afterwards exactly one flag is set: equal if a==b, greater if a>b, less if a<b. CMP has `out_wen`=0 and `out_taken`=0.
- R7: The flags change only when a CMP is accepted. They hold across every other operation and across stalls.
- R8: Jumps have `out_wen`=0 and target pc+sext(imm). They are taken as follows: 0x0D always; 0x0E on equal; 0x0F when not equal; 0x10 on greater; 0x11 on greater or equal; 0x12 on less; 0x13 on less or equal.
- R9: Any other code (for example 0x00 or 0x3F) still produces a beat, with `out_wen`=0 and `out_taken`=0.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_valid`, `out_result`, `out_wen`, `out_taken` and `out_target` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction beat present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_op | input | 6 | Operation code |
| in_a | input | 32 | First operand (destination value for LUI) |
| in_b | input | 32 | Second operand |
| in_imm | input | 16 | Immediate or branch offset |
| in_shamt | input | 5 | Shift count |
| in_pc | input | 32 | Program counter of the instruction |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_result | output | 32 | Result word |
| out_wen | output | 1 | Result must be written to the destination register |
| out_taken | output | 1 | Jump taken |
| out_target | output | 32 | Jump target address |
| flag_eq | output | 1 | Equal flag |
| flag_gt | output | 1 | Greater-than flag |
| flag_lt | output | 1 | Less-than flag |

## Verification
The bench builds the unit with its default 32-bit word, which makes the 16-bit immediate exactly half a word. This width brings several boundaries into reach: the immediate sign bit at bit 15, the half-word split used by LLI and LUI, shift counts up to 31 with the sign bit shifted out, and carries and borrows across bit 31. The consumer's ready signal cycles through fully open and intermittent phases, so results are checked both back to back and while held under stall. Each result is also checked against the flags expected after it.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [5:0] OP_LLI  = 6'h0B;
  localparam logic [5:0] OP_LUI  = 6'h0C;
  localparam logic [5:0] OP_JMP  = 6'h0D;
  localparam logic [5:0] OP_JEQ  = 6'h0E;
  localparam logic [5:0] OP_JNE  = 6'h0F;
  localparam logic [5:0] OP_JGT  = 6'h10;
  localparam logic [5:0] OP_JGE  = 6'h11;
  localparam logic [5:0] OP_JLT  = 6'h12;
  localparam logic [5:0] OP_JLE  = 6'h13;
  localparam logic [5:0] OP_CMP  = 6'h14;
  localparam logic [5:0] OP_INC  = 6'h15;
  localparam logic [5:0] OP_DEC  = 6'h16;
  localparam logic [5:0] OP_SHL  = 6'h17;
  localparam logic [5:0] OP_SHR  = 6'h18;
  localparam logic [5:0] OP_ADD  = 6'h19;
  localparam logic [5:0] OP_SUB  = 6'h1A;
  localparam logic [5:0] OP_AND  = 6'h1B;
  localparam logic [5:0] OP_OR   = 6'h1C;
  localparam logic [5:0] OP_NOT  = 6'h1D;
  localparam logic [5:0] OP_XOR  = 6'h1E;
  localparam logic [5:0] OP_NAND = 6'h1F;
  localparam logic [5:0] OP_NOR  = 6'h20;
  localparam logic [5:0] OP_XNOR = 6'h21;
  localparam logic [5:0] OP_IADD = 6'h25;
  localparam logic [5:0] OP_ISUB = 6'h26;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/exec_datapath.sv
module exec_datapath #(
  parameter int W = 32,
  localparam int IMM_W = W / 2,
  localparam int SH_W  = $clog2(W)
) (
  input  logic [5:0]       op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  output logic [W-1:0]     result,
  output logic             wen
);
  import exec_pkg::*;

  logic [W-1:0] imm_sx;
  assign imm_sx = {{(W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    result = '0;
    wen    = 1'b1;
    case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_INC:  result = a + W'(1);
      OP_DEC:  result = a - W'(1);
      OP_IADD: result = a + imm_sx;
      OP_ISUB: result = a - imm_sx;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_NOT:  result = ~a;
      OP_XOR:  result = a ^ b;
      OP_NAND: result = ~(a & b);
      OP_NOR:  result = ~(a | b);
      OP_XNOR: result = ~(a ^ b);
      OP_SHL:  result = a << shamt;
      OP_SHR:  result = a >> shamt;
      OP_LLI:  result = {{(W-IMM_W){1'b0}}, imm};
      OP_LUI:  result = {imm, a[IMM_W-1:0]};
      default: wen = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_flag_unit.sv
module exec_flag_unit #(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  output exec_pkg::cmp_flags_t  flags
);
  import exec_pkg::*;

  cmp_flags_t next_flags;

  always_comb begin
    next_flags.eq = (a == b);
    next_flags.gt = ($signed(a) > $signed(b));
    next_flags.lt = ($signed(a) < $signed(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= next_flags;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags)); // R6
  AST_FLAGS_SET_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> $onehot(flags)); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags)); // R7
endmodule

// File: rtl/exec_branch_unit.sv
module exec_branch_unit #(
  parameter int W = 32,
  localparam int IMM_W = W / 2
) (
  input  logic [5:0]           op,
  input  exec_pkg::cmp_flags_t flags,
  input  logic [W-1:0]         pc,
  input  logic [IMM_W-1:0]     imm,
  output logic                 taken,
  output logic [W-1:0]         target
);
  import exec_pkg::*;

  assign target = pc + {{(W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    case (op)
      OP_JMP:  taken = 1'b1;
      OP_JEQ:  taken = flags.eq;
      OP_JNE:  taken = !flags.eq;
      OP_JGT:  taken = flags.gt;
      OP_JGE:  taken = flags.gt | flags.eq;
      OP_JLT:  taken = flags.lt;
      OP_JLE:  taken = flags.lt | flags.eq;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int W = 32,
  localparam int IMM_W = W / 2,
  localparam int SH_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [5:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [SH_W-1:0]  in_shamt,
  input  logic [W-1:0]     in_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_wen,
  output logic             out_taken,
  output logic [W-1:0]     out_target,
  output logic             flag_eq,
  output logic             flag_gt,
  output logic             flag_lt
);
  import exec_pkg::*;

  logic         fire;
  logic [W-1:0] dp_result;
  logic         dp_wen;
  logic         br_taken;
  logic [W-1:0] br_target;
  cmp_flags_t   flags;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  exec_datapath #(.W(W)) u_dp (
    .op(in_op), .a(in_a), .b(in_b), .imm(in_imm), .shamt(in_shamt),
    .result(dp_result), .wen(dp_wen)
  );

  exec_flag_unit #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd(fire && (in_op == OP_CMP)),
    .a(in_a), .b(in_b), .flags(flags)
  );

  exec_branch_unit #(.W(W)) u_br (
    .op(in_op), .flags(flags), .pc(in_pc), .imm(in_imm),
    .taken(br_taken), .target(br_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wen    <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= dp_result;
      out_wen    <= dp_wen;
      out_taken  <= br_taken;
      out_target <= br_target;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign flag_eq = flags.eq;
  assign flag_gt = flags.gt;
  assign flag_lt = flags.lt;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wen)
      && $stable(out_taken) && $stable(out_target)); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> !out_wen); // R8
endmodule

// File: tb/tb_exec_unit.sv
module tb_exec_unit;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_pc = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_result, out_target;
  logic        out_wen, out_taken, flag_eq, flag_gt, flag_lt;

  exec_unit #(.W(W)) dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        wen;
    logic        taken;
    logic [31:0] tgt;
    logic        chk_tgt;
    logic [2:0]  flg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic m_eq = 0, m_gt = 0, m_lt = 0;
  int   cyc = 0;
  int   ready_mode = 0;
  logic done = 0;

  function automatic exp_t model(input logic [5:0] op, input logic [31:0] a, b,
                                 input logic [15:0] imm, input logic [4:0] sh,
                                 input logic [31:0] pc, input string tag);
    exp_t e;
    logic [31:0] sx;
    sx = {{16{imm[15]}}, imm};
    e.res = 0; e.wen = 1; e.taken = 0; e.tgt = 0; e.chk_tgt = 0; e.tag = tag;
    case (op)
      6'h19: e.res = a + b;
      6'h1A: e.res = a - b;
      6'h15: e.res = a + 1;
      6'h16: e.res = a - 1;
      6'h25: e.res = a + sx;
      6'h26: e.res = a - sx;
      6'h1B: e.res = a & b;
      6'h1C: e.res = a | b;
      6'h1D: e.res = ~a;
      6'h1E: e.res = a ^ b;
      6'h1F: e.res = ~(a & b);
      6'h20: e.res = ~(a | b);
      6'h21: e.res = ~(a ^ b);
      6'h17: e.res = a << sh;
      6'h18: e.res = a >> sh;
      6'h0B: e.res = {16'h0, imm};
      6'h0C: e.res = {imm, a[15:0]};
      6'h14: begin
        e.wen = 0;
        m_eq = (a == b);
        m_gt = ($signed(a) > $signed(b));
        m_lt = ($signed(a) < $signed(b));
      end
      6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h11, 6'h12, 6'h13: begin
        e.wen = 0; e.chk_tgt = 1; e.tgt = pc + sx;
        case (op)
          6'h0D: e.taken = 1;
          6'h0E: e.taken = m_eq;
          6'h0F: e.taken = !m_eq;
          6'h10: e.taken = m_gt;
          6'h11: e.taken = m_gt || m_eq;
          6'h12: e.taken = m_lt;
          default: e.taken = m_lt || m_eq;
        endcase
      end
      default: e.wen = 0;
    endcase
    e.flg = {m_eq, m_gt, m_lt};
    return e;
  endfunction

  task automatic send(input logic [5:0] op, input logic [31:0] a, b,
                      input logic [15:0] imm, input logic [4:0] sh,
                      input logic [31:0] pc, input string tag);
    q.push_back(model(op, a, b, imm, sh, pc, tag));
    in_op = op; in_a = a; in_b = b; in_imm = imm; in_shamt = sh; in_pc = pc;
    in_valid = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    case (ready_mode)
      0: out_ready = 1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = ($urandom_range(0, 3) != 0);
    endcase
  end

  // monitor: samples at the falling edge, compares against the queue head
  logic        prev_stall = 0;
  logic [31:0] prev_res, prev_tgt;
  logic        prev_wen, prev_taken;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_result == prev_res && out_target == prev_tgt &&
              out_wen == prev_wen && out_taken == prev_taken, "R10 hold",
              out_result, prev_res);
      if (out_valid && !out_ready)
        check(!in_ready, "R10 ready low under stall", {31'b0, in_ready}, 32'h0);
      prev_stall = out_valid && !out_ready;
      prev_res = out_result; prev_tgt = out_target;
      prev_wen = out_wen; prev_taken = out_taken;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", out_result, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_wen == e.wen, {e.tag, " wen"}, {31'b0, out_wen}, {31'b0, e.wen});
          if (e.wen) check(out_result == e.res, {e.tag, " result"}, out_result, e.res);
          check(out_taken == e.taken, {e.tag, " taken"}, {31'b0, out_taken}, {31'b0, e.taken});
          if (e.chk_tgt) check(out_target == e.tgt, {e.tag, " target"}, out_target, e.tgt);
          check({flag_eq, flag_gt, flag_lt} == e.flg, {e.tag, " flags (R7)"},
                {29'b0, flag_eq, flag_gt, flag_lt}, {29'b0, e.flg});
        end
      end
    end
  end

  initial begin
    #10000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] ops [24];
    ops = '{6'h19, 6'h1A, 6'h15, 6'h16, 6'h25, 6'h26, 6'h1B, 6'h1C, 6'h1D, 6'h1E,
            6'h1F, 6'h20, 6'h21, 6'h17, 6'h18, 6'h0B, 6'h0C, 6'h14, 6'h0D, 6'h0E,
            6'h0F, 6'h11, 6'h12, 6'h13};
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(!out_valid && in_ready, "R1 handshake", {30'b0, out_valid, in_ready}, 32'h1);
    check({flag_eq, flag_gt, flag_lt} == 3'b000, "R1 flags",
          {29'b0, flag_eq, flag_gt, flag_lt}, 32'h0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 arithmetic corners
    send(6'h19, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R2 add wrap");
    send(6'h1A, 32'h0, 32'h1, 0, 0, 0, "R2 sub borrow");
    send(6'h15, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 inc wrap");
    send(6'h16, 32'h0, 0, 0, 0, 0, "R2 dec wrap");
    send(6'h25, 32'h10, 0, 16'h8000, 0, 0, "R2 iadd negative imm");
    send(6'h26, 32'h10, 0, 16'hFFFF, 0, 0, "R2 isub of -1");
    // R3 logic
    send(6'h1B, 32'hF0F0_1234, 32'hFF00_FF00, 0, 0, 0, "R3 and");
    send(6'h1D, 32'h0000_FFFF, 0, 0, 0, 0, "R3 not");
    send(6'h1F, 32'hFFFF_0000, 32'hFF00_FF00, 0, 0, 0, "R3 nand");
    send(6'h20, 32'h1, 32'h2, 0, 0, 0, "R3 nor");
    send(6'h21, 32'hAAAA_5555, 32'hAAAA_0000, 0, 0, 0, "R3 xnor");
    // R4 shifts
    send(6'h17, 32'h3, 0, 0, 5'd31, 0, "R4 shl 31");
    send(6'h18, 32'h8000_0000, 0, 0, 5'd31, 0, "R4 shr logical");
    send(6'h18, 32'hDEAD_BEEF, 0, 0, 5'd0, 0, "R4 shift 0");
    // R5 immediate loads
    send(6'h0B, 32'hFFFF_FFFF, 0, 16'hABCD, 0, 0, "R5 lli clears top");
    send(6'h0C, 32'h1234_5678, 0, 16'hABCD, 0, 0, "R5 lui keeps low");
    // R6/R8 compare and jumps
    send(6'h14, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R6 cmp signed less");
    send(6'h12, 0, 0, 16'hFFF0, 0, 32'h100, "R8 jlt taken back");
    send(6'h10, 0, 0, 16'h0008, 0, 32'h100, "R8 jgt not taken");
    send(6'h0F, 0, 0, 16'h0004, 0, 32'h200, "R8 jne");
    send(6'h14, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0, "R6 cmp signed greater");
    send(6'h11, 0, 0, 16'h0010, 0, 32'h40, "R8 jge");
    send(6'h13, 0, 0, 16'h0010, 0, 32'h40, "R8 jle");
    send(6'h14, 32'h55, 32'h55, 0, 0, 0, "R6 cmp equal");
    send(6'h0E, 0, 0, 16'h0020, 0, 32'h80, "R8 jeq");
    send(6'h19, 32'h1, 32'h2, 0, 0, 0, "R7 add keeps flags");
    send(6'h0D, 0, 0, 16'h8000, 0, 32'h0001_0000, "R8 jmp");
    // R9 unknown codes
    send(6'h3F, 32'h1, 32'h2, 16'h5, 0, 0, "R9 op 3F");
    send(6'h00, 32'h1, 32'h2, 16'h5, 0, 0, "R9 op 00");

    // random traffic with back-pressure (R10)
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      for (int i = 0; i < 200; i++) begin
        logic [31:0] a, b;
        logic [5:0] op;
        op = ops[$urandom_range(0, 23)];
        a = $urandom;
        b = ($urandom_range(0, 3) == 0) ? a : $urandom;
        send(op, a, b, 16'($urandom), 5'($urandom), $urandom, "R10 stream");
      end
    end
    ready_mode = 0;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule